// File: doc/BRIEF.md
# Interrupt Mask and Status Controller

This block gathers single-cycle event pulses from the sources of a network MAC queue into a sticky status register and raises one interrupt line while any pending source is unmasked. Software reaches it through a simple register bus: a word address, a write strobe, write data and combinational read data.

The mask register is read-only. It changes only through two write-only addresses. One of them unmasks the bits written as 1, and the other masks them. Software can therefore change one source without a read-modify-write. A write to the mask address leaves the mask alone. Instead it forces status bits to 1, which lets a test raise an interrupt without a real event. Only the sources at bits 1, 2, 5, 6, 7, 10 and 11 exist. Every other bit position is tied to zero.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask register reads 0x00000CE6, so every implemented source is masked. The status register reads 0 and the interrupt output is 0.
- R2: A write to the enable address (word address 2) clears each mask bit written as 1 and leaves mask bits written as 0 unchanged. A mask bit of 0 means the source is enabled.
- R3: A write to the disable address (word address 3) sets each implemented mask bit written as 1 and leaves the others unchanged.
- R4: A write to the mask address (word address 1) does not change the mask. It sets each implemented status bit written as 1, whatever the mask holds, and leaves status bits written as 0 unchanged.
- R5: In both the mask and the status register, bit 0, bits 3 and 4, bits 8 and 9, and bits 31 to 12 always read 0, and writes to them have no effect.
- R6: An event pulse on an implemented source sets its status bit, whether the source is masked or not.
- R7: Writing 1 to a bit at the status address (word address 0) clears that status bit. When an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: The interrupt output is registered. One clock after the registers hold a given state, it equals the OR of all status bits whose mask bit is 0.
- R9: Reads of the enable and disable addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Word address: 0 status, 1 mask, 2 enable, 3 disable |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| evtPulse | input | 32 | One event pulse per source bit |
| irqOut | output | 1 | Interrupt request |

## Verification
The stimulus uses three kinds of write data. All-ones writes show that the reserved bits stay at zero. Single-bit writes show that only the addressed source changes. Zero writes show that a 0 bit leaves its register bit alone. Events are raised on masked and unmasked sources, so the checks can tell a status bit that is set from an interrupt that is actually driven. Further directed cases check that an event wins over a clear in the same cycle, and that the interrupt follows its status bit one cycle later.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic clrStatus;
    logic injStatus;
    logic maskEn;
    logic maskDis;
  } strobe_t;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int ADDR_STATUS = 0,
  parameter int ADDR_MASK   = 1,
  parameter int ADDR_EN     = 2,
  parameter int ADDR_DIS    = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobes,
  output rd_sel_e           rdSel
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(ADDR_EN);
  localparam logic [ADDR_W-1:0] A_DIS    = ADDR_W'(ADDR_DIS);

  always_comb begin
    strobes.clrStatus = busWe && (busAddr == A_STATUS);
    strobes.injStatus = busWe && (busAddr == A_MASK);
    strobes.maskEn    = busWe && (busAddr == A_EN);
    strobes.maskDis   = busWe && (busAddr == A_DIS);
  end

  // enable and disable addresses read back as zero (R9)
  always_comb begin
    if (busAddr == A_STATUS)    rdSel = RD_STATUS;
    else if (busAddr == A_MASK) rdSel = RD_MASK;
    else                        rdSel = RD_ZERO;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0000_0CE6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  rd_sel_e           rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evtPulse,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);
  logic [DATA_W-1:0] maskReg, statusReg;
  logic [DATA_W-1:0] wImpl, evtImpl, setBits, clrBits, onBits, offBits;

  assign wImpl   = wdata & IMPL_MASK;
  assign evtImpl = evtPulse & IMPL_MASK;

  always_comb begin
    onBits  = strobes.maskDis ? wImpl : '0;
    offBits = strobes.maskEn  ? wImpl : '0;
    setBits = evtImpl | (strobes.injStatus ? wImpl : '0);
    clrBits = strobes.clrStatus ? wImpl : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= IMPL_MASK;
      statusReg <= '0;
      irqOut    <= 1'b0;
    end else begin
      // disable dominates enable; event/inject dominates clear
      maskReg   <= ((maskReg & ~offBits) | onBits) & IMPL_MASK;
      statusReg <= ((statusReg & ~clrBits) | setBits) & IMPL_MASK;
      irqOut    <= |(statusReg & ~maskReg);
    end
  end

  always_comb begin
    case (rdSel)
      RD_STATUS: rdata = statusReg;
      RD_MASK:   rdata = maskReg;
      default:   rdata = '0;
    endcase
  end

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((maskReg | statusReg) & ~IMPL_MASK) == '0);

  assert_inject_keeps_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.injStatus |=> maskReg == $past(maskReg));

  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|evtImpl) |=> ((statusReg & $past(evtImpl)) == $past(evtImpl)));

  assert_enable_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.maskEn && !strobes.maskDis) |=> ((maskReg & $past(wImpl)) == '0));

  assert_disable_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskDis |=> ((maskReg & $past(wImpl)) == $past(wImpl)));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((statusReg & ~maskReg) == '0) |=> !irqOut);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_pkg::*;
#(
  parameter int               ADDR_W    = 2,
  parameter int               DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h0000_0CE6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] evtPulse,
  output logic              irqOut
);
  strobe_t strobes;
  rd_sel_e rdSel;

  irq_ctrl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irq_regs #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wdata    (busWdata),
    .evtPulse (evtPulse),
    .rdata    (busRdata),
    .irqOut   (irqOut)
  );

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clrStatus, strobes.injStatus, strobes.maskEn, strobes.maskDis}));
endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
  typedef struct packed {
    logic [1:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] evt;
    logic [1:0]  rdAddr;
    logic [31:0] expRd;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 1'b1, 32'h0000_0002, 32'h0,          2'd1, 32'h0000_0CE4, 1'b0}, // R2
    '{2'd1, 1'b1, 32'hFFFF_FFFF, 32'h0,          2'd0, 32'h0000_0CE6, 1'b1}, // R4 R5
    '{2'd0, 1'b0, 32'h0,         32'h0,          2'd1, 32'h0000_0CE4, 1'b1}, // R4
    '{2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0,          2'd0, 32'h0,         1'b0}, // R7
    '{2'd0, 1'b0, 32'h0,         32'h0000_0400,  2'd0, 32'h0000_0400, 1'b0}, // R6
    '{2'd2, 1'b1, 32'h0000_0400, 32'h0,          2'd1, 32'h0000_08E4, 1'b1}, // R8
    '{2'd3, 1'b1, 32'hFFFF_FFFF, 32'h0,          2'd1, 32'h0000_0CE6, 1'b0}, // R3 R5
    '{2'd0, 1'b0, 32'h0,         32'h0,          2'd2, 32'h0,         1'b0}, // R9
    '{2'd0, 1'b0, 32'h0,         32'h0,          2'd3, 32'h0,         1'b0}, // R9
    '{2'd0, 1'b0, 32'h0,         32'hFFFF_FFFF,  2'd0, 32'h0000_0CE6, 1'b0}, // R5 R6
    '{2'd2, 1'b1, 32'h0000_0080, 32'h0,          2'd0, 32'h0000_0CE6, 1'b1}, // R8
    '{2'd0, 1'b1, 32'h0000_0080, 32'h0,          2'd0, 32'h0000_0C66, 1'b0}, // R7
    '{2'd1, 1'b1, 32'h0,         32'h0,          2'd0, 32'h0000_0C66, 1'b0}  // R4
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] evtPulse = '0;
  logic        irqOut;
  int          nRun = 0;
  int          nFail = 0;

  always #4 clk = ~clk;

  irq_mask_ctrl i_irq_mask_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic doOp(input logic [1:0] a, input logic we, input logic [31:0] wd,
                      input logic [31:0] ev);
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = wd; evtPulse = ev;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0; evtPulse = '0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    readAt(2'd1, rd); check("R1 mask reset", rd, 32'h0000_0CE6);
    readAt(2'd0, rd); check("R1 status reset", rd, 32'h0);
    check("R1 irq reset", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doOp(VECS[i].addr, VECS[i].we, VECS[i].wdata, VECS[i].evt);
      @(negedge clk);
      readAt(VECS[i].rdAddr, rd);
      check($sformatf("vector %0d read", i), rd, VECS[i].expRd);
      check($sformatf("vector %0d R8 irq", i), {31'b0, irqOut}, {31'b0, VECS[i].expIrq});
    end

    // R7: event and clear on bit 7 in the same cycle -> bit stays set
    doOp(2'd0, 1'b1, 32'h0000_0080, 32'h0000_0080);
    @(negedge clk);
    readAt(2'd0, rd); check("R7 event beats clear", rd, 32'h0000_0CE6);
    check("R7 irq after event", {31'b0, irqOut}, 32'h1);

    // R8: irq lags status by one cycle (bit 7 unmasked)
    doOp(2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0);
    @(negedge clk);
    check("R8 irq low after clear", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    busAddr = 2'd1; busWe = 1'b1; busWdata = 32'h0000_0080;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
    readAt(2'd0, rd); check("R4 inject visible", rd, 32'h0000_0080);
    check("R8 irq not yet", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R8 irq one cycle later", {31'b0, irqOut}, 32'h1);
    readAt(2'd1, rd); check("R4 mask untouched", rd, 32'h0000_0C66);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule